// File: doc/BRIEF.md
# Integer ALU with Overflow Signalling

This block is the integer execute unit of a small RISC core. Each cycle it takes two 32-bit operands, a 5-bit shift amount and a 4-bit operation code. It returns a 32-bit result and a one-bit overflow exception flag. Both outputs are registered, so a result appears one clock after its inputs are presented.

Addition and subtraction each come in two forms. The checked form raises the flag on two's-complement overflow. The wrapping form gives the same modular result and never raises the flag. The block also provides bitwise AND, OR and NOT, three shifts of operand A (left logical, right logical, right arithmetic), and signed and unsigned less-than compares that write 0 or 1.

Immediates reach the block already extended on operand B. The block only raises the flag: trap handling, the register file and instruction decode are outside it.

Top module: `alu_core`

## Requirements
- R1: While rst_n is low, result_o and ovf_o read 0. After reset, the outputs for inputs presented before a rising clock edge appear after that edge and hold until the next one.
- R2: Op 0 (checked add) and op 1 (wrapping add) give (A + B) mod 2^32. Op 2 (checked subtract) and op 3 (wrapping subtract) give (A - B) mod 2^32.
- R3: Ops 0 and 2 set ovf_o exactly when the true signed result does not fit in 32 bits. For add, this is when A and B share a sign and the result sign differs. For subtract, this is when the signs of A and B differ and the result sign differs from A.
- R4: Ops 1 and 3 never set ovf_o, including for operands that overflow under ops 0 and 2.
- R5: Op 4 gives A AND B. Op 5 gives A OR B. Op 6 gives NOT A, and operand B has no effect on it.
- R6: Op 7 shifts A left by shamt_i (0 to 31). Bits moved past bit 31 are lost and the vacated low bits are 0, so 0x00000002 shifted by 2 gives 0x00000008.
- R7: Op 8 shifts A right by shamt_i and fills the vacated high bits with 0.
- R8: Op 9 shifts A right by shamt_i and fills the vacated high bits with copies of bit 31. The result rounds toward minus infinity, so -25 shifted by 4 gives -2 (0xFFFFFFFE).
- R9: Op 10 writes 1 to bit 0 when A < B as two's-complement numbers, and 0 otherwise. Bits 31..1 are always 0.
- R10: Op 11 writes 1 to bit 0 when A < B as unsigned numbers, and 0 otherwise. Bits 31..1 are always 0.
- R11: ovf_o is 0 for ops 4 to 11. Unassigned op codes 12 to 15 give a result of 0 and an ovf_o of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code (see requirements) |
| a_i | input | 32 | Operand A, also the value that is shifted |
| b_i | input | 32 | Operand B |
| shamt_i | input | 5 | Shift amount |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The hardest condition to reach from the ports is the overflow boundary. Random operands seldom hit 0x7FFFFFFF + 1, 0x80000000 - 1, or a subtraction of -1 from the largest positive value. Signed compares between operands of opposite sign are rare for the same reason.

The stimulus therefore pairs these edge operands with both the checked and the wrapping opcode. It adds the sign-straddling and equal-operand compares, and shifts by 0 and by 31, before a long stretch of random operands over all codes. The bench model finds overflow by widening both operands to 33 bits, not by the sign rule the design uses.

// File: rtl/alu_pkg.sv
package alu_pkg;

    parameter int ALU_W = 32;

    // Operation codes; values are fixed because decode drives them directly.
    typedef enum logic [3:0] {
        OP_ADD_CHK  = 4'd0,
        OP_ADD_WRAP = 4'd1,
        OP_SUB_CHK  = 4'd2,
        OP_SUB_WRAP = 4'd3,
        OP_AND      = 4'd4,
        OP_OR       = 4'd5,
        OP_NOT      = 4'd6,
        OP_SLL      = 4'd7,
        OP_SRL      = 4'd8,
        OP_SRA      = 4'd9,
        OP_SLT      = 4'd10,
        OP_SLTU     = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_kind_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_NOT = 2'd2
    } bitwise_kind_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   total;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        total   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        sum_o   = total[W-1:0];
        carry_o = total[W];
        // Same-sign inputs to the adder giving a result of the other sign.
        ovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val_i,
    input  logic [SW-1:0] amt_i,
    input  shift_kind_e   kind_i,
    output logic [W-1:0]  out_o
);
    localparam int MSB = W - 1;

    logic [W-1:0]       val_rev;
    logic [W-1:0]       fin_rev;
    logic [SW:0][W-1:0] stg;
    logic               fill;
    logic               left;

    // Left shifts reuse the right-shift barrel by bit-reversing around it.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign val_rev[i] = val_i[MSB-i];
        assign fin_rev[i] = stg[SW][MSB-i];
    end

    assign left   = (kind_i == SH_LEFT);
    assign fill   = (kind_i == SH_RARI) ? val_i[MSB] : 1'b0;
    assign stg[0] = left ? val_rev : val_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int S = 1 << k;
        assign stg[k+1] = amt_i[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
    end

    assign out_o = left ? fin_rev : stg[SW];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  bitwise_kind_e kind_i,
    output logic [W-1:0] out_o
);
    always_comb begin
        unique case (kind_i)
            BW_AND:  out_o = a_i & b_i;
            BW_OR:   out_o = a_i | b_i;
            BW_NOT:  out_o = ~a_i;
            default: out_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = alu_pkg::ALU_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [$clog2(WIDTH)-1:0] shamt_i,
    output logic [WIDTH-1:0] result_o,
    output logic             ovf_o
);
    localparam int SW  = $clog2(WIDTH);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             ovf;
    } out_t;

    out_t          out_d, out_q;
    alu_op_e       op;
    logic          sub_sel;
    logic [WIDTH-1:0] sum;
    logic          carry;
    logic          add_ovf;
    logic [WIDTH-1:0] sh_out;
    logic [WIDTH-1:0] bw_out;
    shift_kind_e   sh_kind;
    bitwise_kind_e bw_kind;
    logic          lt_s, lt_u;

    assign op = alu_op_e'(op_i);

    // Compares share the subtractor with the subtract operations.
    assign sub_sel = (op == OP_SUB_CHK) || (op == OP_SUB_WRAP) ||
                     (op == OP_SLT) || (op == OP_SLTU);

    always_comb begin
        case (op)
            OP_SRL:  sh_kind = SH_RLOG;
            OP_SRA:  sh_kind = SH_RARI;
            default: sh_kind = SH_LEFT;
        endcase
        case (op)
            OP_OR:   bw_kind = BW_OR;
            OP_NOT:  bw_kind = BW_NOT;
            default: bw_kind = BW_AND;
        endcase
    end

    alu_addsub #(.W(WIDTH)) u_addsub (
        .a_i     (a_i),
        .b_i     (b_i),
        .sub_i   (sub_sel),
        .sum_o   (sum),
        .carry_o (carry),
        .ovf_o   (add_ovf)
    );

    alu_shifter #(.W(WIDTH), .SW(SW)) u_shifter (
        .val_i  (a_i),
        .amt_i  (shamt_i),
        .kind_i (sh_kind),
        .out_o  (sh_out)
    );

    alu_bitwise #(.W(WIDTH)) u_bitwise (
        .a_i    (a_i),
        .b_i    (b_i),
        .kind_i (bw_kind),
        .out_o  (bw_out)
    );

    // Signed: sign of the difference, corrected when it overflowed.
    // Unsigned: no carry out of A + ~B + 1 means a borrow occurred.
    assign lt_s = sum[MSB] ^ add_ovf;
    assign lt_u = ~carry;

    always_comb begin
        out_d = '0;
        case (op)
            OP_ADD_CHK, OP_SUB_CHK: begin
                out_d.res = sum;
                out_d.ovf = add_ovf;
            end
            OP_ADD_WRAP, OP_SUB_WRAP: out_d.res = sum;
            OP_AND, OP_OR, OP_NOT:    out_d.res = bw_out;
            OP_SLL, OP_SRL, OP_SRA:   out_d.res = sh_out;
            OP_SLT:  out_d.res = {{(WIDTH-1){1'b0}}, lt_s};
            OP_SLTU: out_d.res = {{(WIDTH-1){1'b0}}, lt_u};
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o = out_q.res;
    assign ovf_o    = out_q.ovf;

    AST_ADD_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD_CHK && a_i[MSB] == b_i[MSB])
        |=> (ovf_o == (result_o[MSB] != $past(a_i[MSB])))); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD_WRAP || op_i == OP_SUB_WRAP) |=> !ovf_o); // R4
    AST_QUIET_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd4) |=> !ovf_o); // R11
    AST_SLL_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SLL && shamt_i != '0) |=> !result_o[0]); // R6
    AST_SRL_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SRL && shamt_i != '0) |=> !result_o[MSB]); // R7
    AST_SRA_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SRA) |=> (result_o[MSB] == $past(a_i[MSB]))); // R8
    AST_SLT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SLT || op_i == OP_SLTU) |=> (result_o[MSB:1] == '0)); // R9
endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [4:0]  shamt_i = '0;
    logic [31:0] result_o;
    logic        ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  sh;
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } item_t;

    item_t exp_q[$];

    always #5 clk = ~clk;

    alu_core u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .shamt_i  (shamt_i),
        .result_o (result_o),
        .ovf_o    (ovf_o)
    );

    // Independent reference: overflow from 33-bit widened arithmetic.
    function automatic logic [32:0] model(logic [3:0] op, logic [31:0] a,
                                          logic [31:0] b, logic [4:0] sh);
        logic signed [32:0] wide;
        logic [31:0] r;
        logic o;
        r = '0;
        o = 1'b0;
        case (op)
            4'd0, 4'd1: begin
                wide = $signed({a[31], a}) + $signed({b[31], b});
                r = wide[31:0];
                o = (op == 4'd0) && (wide[32] != wide[31]);
            end
            4'd2, 4'd3: begin
                wide = $signed({a[31], a}) - $signed({b[31], b});
                r = wide[31:0];
                o = (op == 4'd2) && (wide[32] != wide[31]);
            end
            4'd4:  r = a & b;
            4'd5:  r = a | b;
            4'd6:  r = ~a;
            4'd7:  r = a << sh;
            4'd8:  r = a >> sh;
            4'd9:  r = $signed(a) >>> sh;
            4'd10: r = {31'd0, ($signed(a) < $signed(b))};
            4'd11: r = {31'd0, (a < b)};
            default: r = '0;
        endcase
        return {o, r};
    endfunction

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0, 4'd2: return "R3";
            4'd1, 4'd3: return "R4";
            4'd4, 4'd5, 4'd6: return "R5";
            4'd7:  return "R6";
            4'd8:  return "R7";
            4'd9:  return "R8";
            4'd10: return "R9";
            4'd11: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic drive(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                         logic [4:0] sh, string tag);
        item_t it;
        logic [32:0] m;
        @(negedge clk);
        op_i = op;
        a_i = a;
        b_i = b;
        shamt_i = sh;
        m = model(op, a, b, sh);
        it.op = op;
        it.a = a;
        it.b = b;
        it.sh = sh;
        it.res = m[31:0];
        it.ovf = m[32];
        it.tag = (tag == "") ? tag_of(op) : tag;
        exp_q.push_back(it);
    endtask

    // Monitor: the item driven at a falling edge is registered at the next
    // rising edge and sampled just after it.
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (result_o !== it.res || ovf_o !== it.ovf) begin
                errors++;
                $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got res=%h ovf=%b exp res=%h ovf=%b",
                         it.tag, it.op, it.a, it.b, it.sh, result_o, ovf_o, it.res, it.ovf);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at 0 during reset despite active inputs.
        op_i = 4'd0;
        a_i = 32'h7FFF_FFFF;
        b_i = 32'h1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (result_o !== 32'd0 || ovf_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got res=%h ovf=%b exp res=0 ovf=0", result_o, ovf_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 wrap arithmetic
        drive(4'd1, 32'hFFFF_FFFF, 32'h1, 5'd0, "R2");
        drive(4'd3, 32'h0, 32'h1, 5'd0, "R2");
        drive(4'd0, 32'd5, 32'hFFFF_FFFD, 5'd0, "R2");
        // R3 overflow edges
        drive(4'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, "R3");
        drive(4'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, "R3");
        drive(4'd2, 32'h8000_0000, 32'h1, 5'd0, "R3");
        drive(4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R3");
        drive(4'd2, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 5'd0, "R3");
        // R4 same operands, wrapping flavour
        drive(4'd1, 32'h7FFF_FFFF, 32'h1, 5'd0, "R4");
        drive(4'd3, 32'h8000_0000, 32'h1, 5'd0, "R4");
        // R5 bitwise, NOT ignores B
        drive(4'd4, 32'hF0F0_1234, 32'h0FF0_FFFF, 5'd0, "R5");
        drive(4'd5, 32'hF000_0001, 32'h0000_0F00, 5'd0, "R5");
        drive(4'd6, 32'h1234_5678, 32'hFFFF_FFFF, 5'd0, "R5");
        drive(4'd6, 32'h1234_5678, 32'h0, 5'd0, "R5");
        // R6 left shift
        drive(4'd7, 32'h2, 32'h0, 5'd2, "R6");
        drive(4'd7, 32'hFFFF_FFFF, 32'h0, 5'd31, "R6");
        drive(4'd7, 32'hDEAD_BEEF, 32'h0, 5'd0, "R6");
        // R7 logical right
        drive(4'd8, 32'h8000_0000, 32'h0, 5'd31, "R7");
        drive(4'd8, 32'hF000_0000, 32'h0, 5'd4, "R7");
        // R8 arithmetic right
        drive(4'd9, 32'hFFFF_FFE7, 32'h0, 5'd4, "R8");
        drive(4'd9, 32'h8000_0000, 32'h0, 5'd31, "R8");
        drive(4'd9, 32'h7000_0000, 32'h0, 5'd4, "R8");
        drive(4'd9, 32'hFFFF_FFE7, 32'h0, 5'd0, "R8");
        // R9 signed compare
        drive(4'd10, 32'hFFFF_FFFF, 32'h1, 5'd0, "R9");
        drive(4'd10, 32'h1, 32'hFFFF_FFFF, 5'd0, "R9");
        drive(4'd10, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, "R9");
        drive(4'd10, 32'h55, 32'h55, 5'd0, "R9");
        // R10 unsigned compare
        drive(4'd11, 32'hFFFF_FFFF, 32'h1, 5'd0, "R10");
        drive(4'd11, 32'h1, 32'hFFFF_FFFF, 5'd0, "R10");
        drive(4'd11, 32'h55, 32'h55, 5'd0, "R10");
        // R11 unassigned codes
        drive(4'd12, 32'h7FFF_FFFF, 32'h1, 5'd3, "R11");
        drive(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, "R11");
        // R1 back-to-back results change every cycle
        drive(4'd1, 32'd10, 32'd20, 5'd0, "R1");
        drive(4'd3, 32'd10, 32'd20, 5'd0, "R1");

        for (int n = 0; n < 600; n++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (n % 7 == 0) rb = ra;
            if (n % 11 == 0) ra = {ra[31], 31'h7FFF_FFF0} ^ {27'd0, ra[4:0]};
            drive(4'($urandom_range(0, 15)), ra, rb, 5'($urandom()), "");
        end

        @(negedge clk);
        op_i = 4'd4;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule